// File: doc/BRIEF.md
# Static Memory Bank Timing Controller

This block runs single accesses and read bursts on an asynchronous parallel memory or peripheral that sits behind one of several chip-select banks. A simple internal request port supplies the bank number, byte address, beat count, write data, byte enables and direction. The block then produces the chip selects, the read strobe, the write strobes, byte-select lines, the address and the output-enabled write data. Read data returns with a one-cycle valid flag, and a one-cycle done flag marks the end of every access.

Each bank has its own settings word. It holds setup, pulse, hold, page-pulse and extra wait-state counts in core clock cycles. It also holds a device width of 8, 16 or 32 bits, a choice between per-byte write strobes and a single write strobe with per-byte selects, and a page-mode enable with a page size from 4 to 32 bytes. Reads in page mode keep the strobe running across beats that fall in the same aligned page, and each of those beats uses the shorter page pulse. An external wait input freezes the pulse phase for as long as it is held.

Top module: `smc_bank_ctrl`

## Requirements
- R1: When idle, no chip select is active and `reqReady` is high. During an access, only the chip select of the accepted bank is active. It rises in the cycle after acceptance and stays high from the first setup cycle to the last hold cycle.
- R2: A single beat takes S setup cycles, then max(P,1)+W pulse cycles, then H hold cycles. S, P, H and W are the bank's setup, pulse, hold and wait-state counts. A setup or hold count of zero removes that phase.
- R3: The strobes are active only in pulse cycles. The read strobe is used for reads and the write strobes for writes, and the two are never active together.
- R4: In any pulse cycle where `extWait` is high, the pulse count does not advance, so the strobe stays active for one more cycle.
- R5: The width field encodes the device width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Byte lanes above the device width are never driven or selected. Burst beats step the address by the width in bytes.
- R6: With the strobe style bit clear (byte write), write strobe lane i equals `reqBe[i]` for lanes inside the width, and all select lines stay low.
- R7: With the strobe style bit set (byte select), only write strobe bit 0 pulses. Select lane i is high for the whole access: for writes it follows `reqBe[i]` for lanes inside the width, and for reads it is high for every lane inside the width.
- R8: A read performs `reqLen` beats, with 0 treated as 1. On a bank without page mode, every beat gets its own setup, pulse and hold. A write is always one beat, whatever `reqLen` says.
- R9: Page size codes 0 to 3 select 4, 8, 16 or 32 bytes. On a page-mode read, a next beat that stays inside the same aligned page follows at once, with a pulse of max(PP,1)+W cycles and no hold or setup in between. A beat that crosses the page boundary goes through hold, setup and a full pulse.
- R10: Read data is captured from `memDataIn` on the last pulse cycle of each read beat. Lanes above the width read as zero. `rdValid` is high for exactly the following cycle.
- R11: `done` goes high for one cycle, in the cycle right after the last cycle of the access. In that cycle the chip select is low and `reqReady` is high.
- R12: For a write, `memDataOe` is high and `memDataOut` holds the request data for the whole access. For a read, `memDataOe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present; taken when `reqReady` is high |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqBank | input | BANK_W | Target bank number |
| reqAddr | input | ADDR_W | Byte address of the first beat, aligned to the device width |
| reqLen | input | LEN_W | Number of read beats (0 means 1) |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables for writes |
| bankCfg | input | NUM_BANKS*CFG_W | Packed settings words, bank b at slice b |
| extWait | input | 1 | External wait request |
| memCs | output | NUM_BANKS | Chip selects, active high |
| memAddr | output | ADDR_W | Device address |
| memRe | output | 1 | Read strobe, active high |
| memWe | output | DATA_W/8 | Write strobes, active high |
| memBs | output | DATA_W/8 | Byte-select lines, active high |
| memDataOut | output | DATA_W | Write data to the device |
| memDataOe | output | 1 | Output enable for `memDataOut` |
| memDataIn | input | DATA_W | Read data from the device |
| rdData | output | DATA_W | Captured read data |
| rdValid | output | 1 | `rdData` valid for one cycle |
| done | output | 1 | Access finished |

## Verification
The assertions assume that a request is offered only while `reqReady` is high and is withdrawn in the cycle after it is taken. They also assume that `reqBank` names an existing bank, that the address is aligned to the bank's width, and that the settings words do not change during an access. The stimulus keeps to these rules: each request is raised on a falling edge, only when the reference model is idle, and is dropped one cycle later. The settings are written once, before reset is released. `extWait` follows a fixed periodic pattern that is enabled only in the second half of the run, so the first half can check cycle counts exactly.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam int SMC_CNT_W = 5;

  typedef struct packed {
    logic [SMC_CNT_W-1:0] setupCyc;
    logic [SMC_CNT_W-1:0] pulseCyc;
    logic [SMC_CNT_W-1:0] holdCyc;
    logic [SMC_CNT_W-1:0] pageCyc;
    logic [SMC_CNT_W-1:0] waitCyc;
  } bankTiming_t;

  typedef struct packed {
    logic [1:0] devWidth;
    logic       byteSel;
    logic       pageOn;
    logic [1:0] pageSize;
  } bankShape_t;

  typedef struct packed {
    bankTiming_t tim;
    bankShape_t  shp;
  } bankCfg_t;

  localparam int CFG_W = $bits(bankCfg_t);

  typedef struct packed {
    logic busy;
    logic load;
    logic advance;
    logic capture;
    logic strobe;
    logic finish;
  } seqCtl_t;

  typedef struct packed {
    logic lastBeat;
    logic pageNext;
  } seqStat_t;

endpackage

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        extWait,
  input  bankTiming_t tim,
  input  seqStat_t    stat,
  output seqCtl_t     ctl
);

  localparam int LEN_CW = SMC_CNT_W + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_t;

  phase_t              ph, phNext;
  logic [LEN_CW-1:0]   cnt, cntNext;
  logic [LEN_CW-1:0]   fullLen, pageLen;
  logic                beatEnd, beatStart;

  always_comb begin
    fullLen = ((tim.pulseCyc == '0) ? LEN_CW'(1) : LEN_CW'(tim.pulseCyc)) + LEN_CW'(tim.waitCyc);
    pageLen = ((tim.pageCyc == '0) ? LEN_CW'(1) : LEN_CW'(tim.pageCyc)) + LEN_CW'(tim.waitCyc);
  end

  always_comb begin
    phNext     = ph;
    cntNext    = cnt;
    ctl        = '0;
    ctl.busy   = (ph != PH_IDLE);
    ctl.strobe = (ph == PH_PULSE);
    beatEnd    = 1'b0;
    beatStart  = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          beatStart = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cnt == LEN_CW'(1)) begin
          phNext  = PH_PULSE;
          cntNext = fullLen;
        end else begin
          cntNext = cnt - LEN_CW'(1);
        end
      end
      PH_PULSE: begin
        if (!extWait) begin
          if (cnt == LEN_CW'(1)) begin
            ctl.capture = 1'b1;
            if (!stat.lastBeat && stat.pageNext) begin
              ctl.advance = 1'b1;
              cntNext     = pageLen;
            end else if (tim.holdCyc != '0) begin
              phNext  = PH_HOLD;
              cntNext = LEN_CW'(tim.holdCyc);
            end else begin
              beatEnd = 1'b1;
            end
          end else begin
            cntNext = cnt - LEN_CW'(1);
          end
        end
      end
      PH_HOLD: begin
        if (cnt == LEN_CW'(1)) beatEnd = 1'b1;
        else                   cntNext = cnt - LEN_CW'(1);
      end
      default: ;
    endcase

    if (beatEnd) begin
      if (stat.lastBeat) begin
        phNext     = PH_IDLE;
        ctl.finish = 1'b1;
      end else begin
        ctl.advance = 1'b1;
        beatStart   = 1'b1;
      end
    end

    if (beatStart) begin
      if (tim.setupCyc != '0) begin
        phNext  = PH_SETUP;
        cntNext = LEN_CW'(tim.setupCyc);
      end else begin
        phNext  = PH_PULSE;
        cntNext = fullLen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      ph  <= phNext;
      cnt <= cntNext;
    end
  end

endmodule

// File: rtl/smc_path.sv
module smc_path
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  localparam int LANES    = DATA_W / 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  seqCtl_t                    ctl,
  input  logic                       reqWrite,
  input  logic [BANK_W-1:0]          reqBank,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [LEN_W-1:0]           reqLen,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic [LANES-1:0]           reqBe,
  input  logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  input  logic [DATA_W-1:0]          memDataIn,
  output bankTiming_t                curTim,
  output seqStat_t                   stat,
  output logic [NUM_BANKS-1:0]       memCs,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memRe,
  output logic [LANES-1:0]           memWe,
  output logic [LANES-1:0]           memBs,
  output logic [DATA_W-1:0]          memDataOut,
  output logic                       memDataOe,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid,
  output logic                       done
);

  bankCfg_t            cfgArr [NUM_BANKS];
  bankCfg_t            curCfg;
  logic [BANK_W-1:0]   bankQ, selBank;
  logic [ADDR_W-1:0]   addrQ, nextAddr, pageMask;
  logic [DATA_W-1:0]   wdataQ, dataMask;
  logic [LANES-1:0]    beQ, laneMask;
  logic                writeQ;
  logic [LEN_W-1:0]    beatsQ;
  logic [2:0]          beatBytes;
  logic                wrPulse;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cfg
    assign cfgArr[b] = bankCfg[b*CFG_W +: CFG_W];
  end

  assign selBank = ctl.busy ? bankQ : reqBank;
  assign curCfg  = cfgArr[selBank];
  assign curTim  = curCfg.tim;

  always_comb begin
    unique case (curCfg.shp.devWidth)
      2'd0:    beatBytes = 3'd1;
      2'd1:    beatBytes = 3'd2;
      default: beatBytes = 3'd4;
    endcase
    unique case (curCfg.shp.pageSize)
      2'd0:    pageMask = ADDR_W'(3);
      2'd1:    pageMask = ADDR_W'(7);
      2'd2:    pageMask = ADDR_W'(15);
      default: pageMask = ADDR_W'(31);
    endcase
  end

  assign nextAddr      = addrQ + ADDR_W'(beatBytes);
  assign stat.lastBeat = (beatsQ == LEN_W'(1));
  assign stat.pageNext = !writeQ && curCfg.shp.pageOn && ((nextAddr & pageMask) != '0);

  assign wrPulse = ctl.strobe && writeQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[g] = (beatBytes > 3'(g));
    assign dataMask[g*8 +: 8] = {8{laneMask[g]}};
    assign memBs[g] = ctl.busy && curCfg.shp.byteSel && laneMask[g] && (writeQ ? beQ[g] : 1'b1);
    if (g == 0) begin : g_first
      assign memWe[g] = wrPulse && (curCfg.shp.byteSel || (beQ[g] && laneMask[g]));
    end else begin : g_rest
      assign memWe[g] = wrPulse && !curCfg.shp.byteSel && beQ[g] && laneMask[g];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    assign memCs[b] = ctl.busy && (bankQ == BANK_W'(b));
  end

  assign memAddr    = addrQ;
  assign memRe      = ctl.strobe && !writeQ;
  assign memDataOut = wdataQ;
  assign memDataOe  = ctl.busy && writeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankQ   <= '0;
      addrQ   <= '0;
      wdataQ  <= '0;
      beQ     <= '0;
      writeQ  <= 1'b0;
      beatsQ  <= LEN_W'(1);
      rdData  <= '0;
      rdValid <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (ctl.load) begin
        bankQ  <= reqBank;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
        writeQ <= reqWrite;
        beatsQ <= (reqWrite || reqLen == '0) ? LEN_W'(1) : reqLen;
      end else if (ctl.advance) begin
        addrQ  <= nextAddr;
        beatsQ <= beatsQ - LEN_W'(1);
      end
      rdValid <= ctl.capture && !writeQ;
      if (ctl.capture && !writeQ) rdData <= memDataIn & dataMask;
      done <= ctl.finish;
    end
  end

endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
  import smc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  localparam int LANES    = DATA_W / 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic                       reqWrite,
  input  logic [BANK_W-1:0]          reqBank,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [LEN_W-1:0]           reqLen,
  input  logic [DATA_W-1:0]          reqWdata,
  input  logic [LANES-1:0]           reqBe,
  input  logic [NUM_BANKS*CFG_W-1:0] bankCfg,
  input  logic                       extWait,
  output logic [NUM_BANKS-1:0]       memCs,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memRe,
  output logic [LANES-1:0]           memWe,
  output logic [LANES-1:0]           memBs,
  output logic [DATA_W-1:0]          memDataOut,
  output logic                       memDataOe,
  input  logic [DATA_W-1:0]          memDataIn,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid,
  output logic                       done
);

  seqCtl_t     ctl;
  seqStat_t    stat;
  bankTiming_t curTim;

  assign reqReady = !ctl.busy;

  smc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .extWait  (extWait),
    .tim      (curTim),
    .stat     (stat),
    .ctl      (ctl)
  );

  smc_path #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqBank    (reqBank),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWdata   (reqWdata),
    .reqBe      (reqBe),
    .bankCfg    (bankCfg),
    .memDataIn  (memDataIn),
    .curTim     (curTim),
    .stat       (stat),
    .memCs      (memCs),
    .memAddr    (memAddr),
    .memRe      (memRe),
    .memWe      (memWe),
    .memBs      (memBs),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .done       (done)
  );

endmodule

// File: rtl/smc_bank_ctrl_chk.sv
module smc_bank_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  localparam int LANES    = DATA_W / 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reqReady,
  input logic                 extWait,
  input logic [NUM_BANKS-1:0] memCs,
  input logic                 memRe,
  input logic [LANES-1:0]     memWe,
  input logic [DATA_W-1:0]    memDataOut,
  input logic                 memDataOe,
  input logic                 rdValid,
  input logic                 done
);

  logic anyStrobe;
  assign anyStrobe = memRe || (|memWe);

  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(memCs));
  p_idle_no_cs_r1: assert property (@(posedge clk) disable iff (rst) reqReady |-> (memCs == '0));
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (rst) anyStrobe |-> (|memCs));
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (rst) !(memRe && (|memWe)));
  p_wait_keeps_strobe_r4: assert property (@(posedge clk) disable iff (rst) (anyStrobe && extWait) |=> anyStrobe);
  p_rdvalid_after_re_r10: assert property (@(posedge clk) disable iff (rst) rdValid |-> $past(memRe));
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_after_cs_r11: assert property (@(posedge clk) disable iff (rst) done |-> (reqReady && $past(|memCs)));
  p_oe_in_cs_r12: assert property (@(posedge clk) disable iff (rst) memDataOe |-> (|memCs));
  p_dout_stable_r12: assert property (@(posedge clk) disable iff (rst) (memDataOe && $past(memDataOe)) |-> $stable(memDataOut));

endmodule

bind smc_bank_ctrl smc_bank_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqReady   (reqReady),
  .extWait    (extWait),
  .memCs      (memCs),
  .memRe      (memRe),
  .memWe      (memWe),
  .memDataOut (memDataOut),
  .memDataOe  (memDataOe),
  .rdValid    (rdValid),
  .done       (done)
);

// File: tb/smc_bank_ctrl_tb.sv
module smc_bank_ctrl_tb;
  import smc_pkg::*;

  localparam int NB     = 4;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 4;
  localparam int LANES  = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic                   reqValid = 1'b0;
  logic                   reqReady;
  logic                   reqWrite = 1'b0;
  logic [1:0]             reqBank = '0;
  logic [ADDR_W-1:0]      reqAddr = '0;
  logic [LEN_W-1:0]       reqLen = '0;
  logic [DATA_W-1:0]      reqWdata = '0;
  logic [LANES-1:0]       reqBe = '0;
  logic [NB*CFG_W-1:0]    cfgFlat = '0;
  logic                   extWait = 1'b0;
  logic [NB-1:0]          memCs;
  logic [ADDR_W-1:0]      memAddr;
  logic                   memRe;
  logic [LANES-1:0]       memWe, memBs;
  logic [DATA_W-1:0]      memDataOut, memDataIn, rdData;
  logic                   memDataOe, rdValid, done;

  function automatic logic [31:0] devWord(input logic [ADDR_W-1:0] a);
    logic [7:0] k;
    k = a[7:0];
    return {k ^ 8'h3C, k + 8'h11, ~k, k};
  endfunction

  assign memDataIn = devWord(memAddr);

  smc_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata), .reqBe(reqBe),
    .bankCfg(cfgFlat), .extWait(extWait), .memCs(memCs), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memBs(memBs), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .rdData(rdData), .rdValid(rdValid), .done(done)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit waitMode = 0;
  bankCfg_t cfgs [NB];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int           mPh = 0;     // 0 idle, 1 setup, 2 pulse, 3 hold
  int           mCnt = 0;
  int           mBank = 0;
  int           mBeats = 0;
  bit           mWrite = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [31:0]  mWd = '0;
  logic [3:0]   mBe = '0;
  bit           mDone = 0;
  bit           mRv = 0;
  logic [31:0]  mRd = '0;

  function automatic int widthBytes(input int b);
    return (cfgs[b].shp.devWidth == 0) ? 1 : (cfgs[b].shp.devWidth == 1) ? 2 : 4;
  endfunction
  function automatic logic [3:0] lanesOf(input int b);
    return (widthBytes(b) == 1) ? 4'b0001 : (widthBytes(b) == 2) ? 4'b0011 : 4'b1111;
  endfunction
  function automatic int mainPulse(input int b);
    return ((cfgs[b].tim.pulseCyc == 0) ? 1 : int'(cfgs[b].tim.pulseCyc)) + int'(cfgs[b].tim.waitCyc);
  endfunction
  function automatic int shortPulse(input int b);
    return ((cfgs[b].tim.pageCyc == 0) ? 1 : int'(cfgs[b].tim.pageCyc)) + int'(cfgs[b].tim.waitCyc);
  endfunction
  function automatic bit samePage(input int b, input logic [ADDR_W-1:0] a);
    int pg;
    pg = 4 << cfgs[b].shp.pageSize;
    return ((int'(a) + widthBytes(b)) % pg) != 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mPh = 0; mDone = 0; mRv = 0;
    end else begin
      bit endOfBeat, startBeat, nDone, nRv;
      endOfBeat = 0; startBeat = 0; nDone = 0; nRv = 0;
      case (mPh)
        0: if (reqValid) begin
             mBank = int'(reqBank); mWrite = reqWrite; mAddr = reqAddr;
             mWd = reqWdata; mBe = reqBe;
             mBeats = (reqWrite || reqLen == 0) ? 1 : int'(reqLen);
             startBeat = 1;
           end
        1: if (mCnt == 1) begin mPh = 2; mCnt = mainPulse(mBank); end else mCnt--;
        2: if (!extWait) begin
             if (mCnt == 1) begin
               if (!mWrite) begin
                 nRv = 1;
                 mRd = devWord(mAddr) & {{8{lanesOf(mBank)[3]}}, {8{lanesOf(mBank)[2]}},
                                          {8{lanesOf(mBank)[1]}}, {8{lanesOf(mBank)[0]}}};
               end
               if (mBeats > 1 && !mWrite && cfgs[mBank].shp.pageOn && samePage(mBank, mAddr)) begin
                 mAddr = mAddr + ADDR_W'(widthBytes(mBank)); mBeats--; mCnt = shortPulse(mBank);
               end else if (cfgs[mBank].tim.holdCyc != 0) begin
                 mPh = 3; mCnt = int'(cfgs[mBank].tim.holdCyc);
               end else endOfBeat = 1;
             end else mCnt--;
           end
        3: if (mCnt == 1) endOfBeat = 1; else mCnt--;
        default: ;
      endcase
      if (endOfBeat) begin
        if (mBeats == 1) begin mPh = 0; nDone = 1; end
        else begin mAddr = mAddr + ADDR_W'(widthBytes(mBank)); mBeats--; startBeat = 1; end
      end
      if (startBeat) begin
        if (cfgs[mBank].tim.setupCyc != 0) begin mPh = 1; mCnt = int'(cfgs[mBank].tim.setupCyc); end
        else begin mPh = 2; mCnt = mainPulse(mBank); end
      end
      mDone = nDone; mRv = nRv;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] lanes, expWe, expBs;
      bit strobe;
      lanes  = lanesOf(mBank);
      strobe = (mPh == 2);
      expWe  = '0; expBs = '0;
      if (strobe && mWrite) expWe = cfgs[mBank].shp.byteSel ? 4'b0001 : (mBe & lanes);
      if (mPh != 0 && cfgs[mBank].shp.byteSel) expBs = mWrite ? (mBe & lanes) : lanes;
      chk("R1 chip select", 32'(memCs), (mPh != 0) ? 32'(1 << mBank) : 32'd0);
      chk("R1 ready", 32'(reqReady), 32'(mPh == 0));
      chk(extWait ? "R4 read strobe under wait" : "R3 read strobe", 32'(memRe), 32'(strobe && !mWrite));
      chk(cfgs[mBank].shp.byteSel ? "R7 write strobes" : "R6 write strobes", 32'(memWe), 32'(expWe));
      chk(cfgs[mBank].shp.byteSel ? "R7 select lines" : "R6 select lines", 32'(memBs), 32'(expBs));
      if (mPh != 0) chk("R5 address", 32'(memAddr), 32'(mAddr));
      chk("R12 output enable", 32'(memDataOe), 32'(mPh != 0 && mWrite));
      if (mPh != 0 && mWrite) chk("R12 write data", memDataOut, mWd);
      chk("R10 read valid", 32'(rdValid), 32'(mRv));
      if (mRv) chk("R10 read data", rdData, mRd);
      chk("R11 done", 32'(done), 32'(mDone));
    end
  end

  always @(negedge clk) extWait = waitMode && ((cyc % 4) == 1);

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input int bank, input int addr, input int len,
                       input logic [31:0] wd, input logic [3:0] be,
                       input int expCs, input string tag);
    int csCycles;
    while (mPh != 0) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBank = 2'(bank); reqAddr = ADDR_W'(addr);
    reqLen = LEN_W'(len); reqWdata = wd; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    csCycles = 0;
    while (!done) begin
      if (|memCs) csCycles++;
      @(negedge clk);
    end
    if (expCs >= 0) chk(tag, 32'(csCycles), 32'(expCs));
  endtask

  initial begin
    cfgs[0] = '{tim: '{setupCyc: 5'd2, pulseCyc: 5'd3, holdCyc: 5'd1, pageCyc: 5'd0, waitCyc: 5'd0},
                shp: '{devWidth: 2'd2, byteSel: 1'b0, pageOn: 1'b0, pageSize: 2'd0}};
    cfgs[1] = '{tim: '{setupCyc: 5'd0, pulseCyc: 5'd0, holdCyc: 5'd0, pageCyc: 5'd0, waitCyc: 5'd2},
                shp: '{devWidth: 2'd1, byteSel: 1'b1, pageOn: 1'b0, pageSize: 2'd0}};
    cfgs[2] = '{tim: '{setupCyc: 5'd1, pulseCyc: 5'd4, holdCyc: 5'd2, pageCyc: 5'd2, waitCyc: 5'd1},
                shp: '{devWidth: 2'd0, byteSel: 1'b0, pageOn: 1'b1, pageSize: 2'd1}};
    cfgs[3] = '{tim: '{setupCyc: 5'd0, pulseCyc: 5'd2, holdCyc: 5'd0, pageCyc: 5'd0, waitCyc: 5'd0},
                shp: '{devWidth: 2'd3, byteSel: 1'b1, pageOn: 1'b1, pageSize: 2'd2}};
    for (int b = 0; b < NB; b++) cfgFlat[b*CFG_W +: CFG_W] = cfgs[b];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset: no chip select", 32'(memCs), 32'd0);
    chk("R1 reset: ready", 32'(reqReady), 32'd1);
    chk("R11 reset: done low", 32'(done), 32'd0);

    issue(1, 0, 'h100, 0, 32'hDEADBEEF, 4'b1010, 6, "R2 write duration bank0");
    issue(0, 0, 'h104, 0, '0, 4'b0000, 6, "R2 read duration bank0");
    issue(1, 1, 'h202, 0, 32'h0000A55A, 4'b0001, 3, "R2 zero setup/hold bank1");
    issue(0, 1, 'h200, 3, '0, 4'b0000, 9, "R8 non-page burst bank1");
    issue(0, 2, 'h005, 6, '0, 4'b0000, 28, "R9 page burst crossing bank2");
    issue(0, 3, 'h008, 5, '0, 4'b0000, 7, "R9 page burst 32-bit bank3");
    issue(1, 3, 'h040, 7, 32'h12345678, 4'b0110, 2, "R8 write ignores length");
    issue(1, 2, 'h013, 0, 32'h000000C3, 4'b1111, 8, "R5 8-bit write bank2");
    issue(0, 2, 'h010, 0, '0, 4'b0000, 8, "R10 8-bit read bank2");
    issue(0, 3, 'h01C, 2, '0, 4'b0000, 4, "R9 page boundary at second beat");

    waitMode = 1;
    issue(0, 0, 'h300, 1, '0, 4'b0000, -1, "");
    issue(1, 0, 'h304, 0, 32'hCAFEF00D, 4'b0101, -1, "");
    issue(0, 2, 'h021, 5, '0, 4'b0000, -1, "");
    issue(1, 1, 'h050, 0, 32'h00003C3C, 4'b0010, -1, "");
    issue(0, 3, 'h060, 6, '0, 4'b0000, -1, "");
    waitMode = 0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule